// File: doc/BRIEF.md
# Compartment Address Decoder

This block sits between a processor-side address bus and one group of addressable resources. The 32-bit address space is cut into equal compartments of 2^SHIFT_RIGHT addresses each. The resource group owns a closed range of compartment numbers, from START_C up to END_C. When the bus address falls in that range, the decoder raises a select and passes the read and write strobes through. It also gives the resources an offset that counts from the start of their first compartment.

Only a window of address bits is decoded. The SHIFT_RIGHT low bits choose a word inside a compartment. Bit 31 and the SHIFT_LEFT bits below it are ignored, so a narrow comparator is enough. When the decoder is not selected, its read data is forced to zero. Several decoders on one bus can therefore have their read data merged with a plain OR.

Top module: `comp_decoder`

## Requirements
- R1: The compartment number is address bits [30-SHIFT_LEFT : SHIFT_RIGHT], which is 31-SHIFT_LEFT-SHIFT_RIGHT bits wide. With the defaults (SHIFT_RIGHT=10, SHIFT_LEFT=0) this is bits 30..10, so setting bit 30 changes the compartment number.
- R2: `sel` is 1 exactly when the compartment number lies between START_C and END_C, both ends included. With the defaults START_C=4 and END_C=5, this is addresses 0x1000 to 0x17FF.
- R3: Address bit 31 and the low SHIFT_RIGHT bits have no effect on `sel`.
- R4: While `sel` is 1, `rsrc_off` equals ((compartment - START_C) << SHIFT_RIGHT) OR'd with the low SHIFT_RIGHT address bits, zero-extended to 32 bits. While `sel` is 0, `rsrc_off` is 0.
- R5: `rsrc_wr` equals `bus_wr` AND `sel`.
- R6: `rsrc_rd` equals `bus_rd` AND `sel`.
- R7: `bus_rdata` equals `rsrc_rdata` while `sel` is 1 and equals 0 otherwise.
- R8: When START_C equals END_C, only that single compartment selects. With START_C=END_C=0 this is addresses 0x000 to 0x3FF, whatever the value of bit 31.
- R9: The design fails to elaborate when END_C < START_C, or when the decoded window has no bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_addr | input | 32 | Processor byte address |
| bus_wr | input | 1 | Write strobe from the bus |
| bus_rd | input | 1 | Read strobe from the bus |
| rsrc_rdata | input | DATA_W | Read data returned by the resources |
| sel | output | 1 | Address lies in the owned compartments |
| rsrc_off | output | 32 | Offset from the start of compartment START_C |
| rsrc_wr | output | 1 | Write strobe gated by the select |
| rsrc_rd | output | 1 | Read strobe gated by the select |
| bus_rdata | output | DATA_W | Read data, zero when not selected |

## Verification
The block holds no state, so any fault appears at the ports in the same cycle as the address that exposes it. A misplaced window edge shows up as a wrong `sel` for an address one compartment outside the range, or for an address with bit 30 or bit 31 set. A wrong base subtraction shows up as an offset that does not restart at 0 at START_C. Vectors sit on both range edges and just past them, so an off-by-one in the inclusive compare shows up immediately.

// File: rtl/cdec_pkg.sv
package cdec_pkg;
   localparam int ADDR_W = 32;

   function automatic int win_width(input int shr, input int shl);
      return (ADDR_W - 1 - shl) - shr;
   endfunction
endpackage

// File: rtl/cdec_field.sv
module cdec_field #(
   parameter int SHR   = 10,
   parameter int SHL   = 0,
   localparam int WIN  = cdec_pkg::win_width(SHR, SHL),
   localparam int TOP  = SHR + WIN - 1
) (
   input  logic [cdec_pkg::ADDR_W-1:0] addr,
   output logic [WIN-1:0]              comp,
   output logic [SHR-1:0]              low
);
   logic unused_hi;

   assign comp = addr[TOP:SHR];
   assign low  = addr[SHR-1:0];
   assign unused_hi = ^addr[cdec_pkg::ADDR_W-1:TOP+1];
endmodule

// File: rtl/cdec_match.sv
module cdec_match #(
   parameter int WIN     = 21,
   parameter int START_C = 4,
   parameter int END_C   = 5
) (
   input  logic [WIN-1:0] comp,
   output logic           hit
);
   localparam logic [WIN-1:0] LO = START_C[WIN-1:0];
   localparam logic [WIN-1:0] HI = END_C[WIN-1:0];

   generate
      if (START_C == END_C) begin : g_single
         assign hit = (comp == LO);
      end else if (START_C == 0) begin : g_from_zero
         assign hit = (comp <= HI);
      end else begin : g_range
         assign hit = (comp >= LO) && (comp <= HI);
      end
   endgenerate
endmodule

// File: rtl/cdec_offset.sv
module cdec_offset #(
   parameter int SHR     = 10,
   parameter int WIN     = 21,
   parameter int START_C = 4,
   localparam int PAD    = cdec_pkg::ADDR_W - WIN - SHR
) (
   input  logic [WIN-1:0]              comp,
   input  logic [SHR-1:0]              low,
   input  logic                        hit,
   output logic [cdec_pkg::ADDR_W-1:0] off
);
   localparam logic [WIN-1:0] LO = START_C[WIN-1:0];
   logic [WIN-1:0] rel;

   assign rel = comp - LO;
   assign off = hit ? {{PAD{1'b0}}, rel, low} : '0;
endmodule

// File: rtl/comp_decoder.sv
module comp_decoder #(
   parameter int SHIFT_RIGHT = 10,
   parameter int SHIFT_LEFT  = 0,
   parameter int START_C     = 4,
   parameter int END_C       = 5,
   parameter int DATA_W      = 32
) (
   input  logic [31:0]       bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] rsrc_rdata,
   output logic              sel,
   output logic [31:0]       rsrc_off,
   output logic              rsrc_wr,
   output logic              rsrc_rd,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int WIN   = cdec_pkg::win_width(SHIFT_RIGHT, SHIFT_LEFT);
   localparam int NCOMP = END_C - START_C + 1;
   localparam longint SPAN = longint'(NCOMP) << SHIFT_RIGHT;

   generate
      if (END_C < START_C) begin : g_bad_range
         $error("comp_decoder: END_C below START_C");  // R9
      end
      if (WIN < 1 || SHIFT_RIGHT < 1) begin : g_bad_window
         $error("comp_decoder: empty decode window");  // R9
      end
   endgenerate

   logic [WIN-1:0]         comp;
   logic [SHIFT_RIGHT-1:0] low;
   logic                   hit;

   cdec_field #(.SHR(SHIFT_RIGHT), .SHL(SHIFT_LEFT)) u_field (
      .addr(bus_addr), .comp(comp), .low(low)
   );

   cdec_match #(.WIN(WIN), .START_C(START_C), .END_C(END_C)) u_match (
      .comp(comp), .hit(hit)
   );

   cdec_offset #(.SHR(SHIFT_RIGHT), .WIN(WIN), .START_C(START_C)) u_off (
      .comp(comp), .low(low), .hit(hit), .off(rsrc_off)
   );

   assign sel       = hit;
   assign rsrc_wr   = bus_wr & hit;
   assign rsrc_rd   = bus_rd & hit;
   assign bus_rdata = hit ? rsrc_rdata : '0;

   always_comb begin
      AST_WR_GATED:    assert (!rsrc_wr || (sel && bus_wr));                         // R5
      AST_RD_GATED:    assert (!rsrc_rd || (sel && bus_rd));                         // R6
      AST_RDATA_QUIET: assert (sel || bus_rdata == '0);                              // R7
      AST_OFF_SPAN:    assert (!sel || longint'(rsrc_off) < SPAN);                   // R4
      AST_OFF_LOW:     assert (!sel || rsrc_off[SHIFT_RIGHT-1:0] == bus_addr[SHIFT_RIGHT-1:0]); // R4
   end
endmodule

// File: tb/comp_decoder_bench.sv
module comp_decoder_bench;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;

   logic [31:0] addr;
   logic        wr, rd;
   logic [31:0] rdata;
   logic        sel;
   logic [31:0] off;
   logic        owr, ord;
   logic [31:0] brdata;

   logic [7:0]  rdata1, brdata1;
   logic        sel1, owr1, ord1;
   logic [31:0] off1;

   comp_decoder u_comp_decoder (
      .bus_addr(addr), .bus_wr(wr), .bus_rd(rd), .rsrc_rdata(rdata),
      .sel(sel), .rsrc_off(off), .rsrc_wr(owr), .rsrc_rd(ord), .bus_rdata(brdata)
   );

   comp_decoder #(.START_C(0), .END_C(0), .DATA_W(8)) u_comp_decoder_one (
      .bus_addr(addr), .bus_wr(wr), .bus_rd(rd), .rsrc_rdata(rdata1),
      .sel(sel1), .rsrc_off(off1), .rsrc_wr(owr1), .rsrc_rd(ord1), .bus_rdata(brdata1)
   );

   typedef struct packed {
      logic [31:0] a;
      logic        w;
      logic        r;
      logic [31:0] d;
      logic        e_sel;
      logic [31:0] e_off;
      logic [31:0] e_rd;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_1000, 1'b1, 1'b0, 32'h0000_AAAA, 1'b1, 32'h0000_0000, 32'h0000_AAAA},
      '{32'h0000_17FF, 1'b0, 1'b1, 32'h0000_1234, 1'b1, 32'h0000_07FF, 32'h0000_1234},
      '{32'h0000_0FFF, 1'b1, 1'b1, 32'h0000_5555, 1'b0, 32'h0000_0000, 32'h0000_0000},
      '{32'h0000_1800, 1'b1, 1'b0, 32'hDEAD_BEEF, 1'b0, 32'h0000_0000, 32'h0000_0000},
      '{32'h8000_1400, 1'b0, 1'b1, 32'h0000_0077, 1'b1, 32'h0000_0400, 32'h0000_0077},
      '{32'h4000_1000, 1'b1, 1'b1, 32'h0000_0099, 1'b0, 32'h0000_0000, 32'h0000_0000},
      '{32'h0000_1523, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, 32'h0000_0523, 32'hFFFF_FFFF},
      '{32'h0000_2000, 1'b0, 1'b1, 32'h0000_0001, 1'b0, 32'h0000_0000, 32'h0000_0000},
      '{32'h8000_17FF, 1'b0, 1'b0, 32'h0000_0042, 1'b1, 32'h0000_07FF, 32'h0000_0042}
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic apply(input logic [31:0] a, input logic w, input logic r,
                        input logic [31:0] d, input logic [7:0] d1);
      @(posedge clk);
      addr = a; wr = w; rd = r; rdata = d; rdata1 = d1;
      @(negedge clk);
   endtask

   initial begin
      addr = '0; wr = 1'b0; rd = 1'b0; rdata = '0; rdata1 = '0;
      @(negedge clk);
      // idle state: address 0 is outside compartments 4..5
      check("R2", "idle sel", {31'd0, sel}, 32'd0);
      check("R4", "idle off", off, 32'd0);
      check("R7", "idle rdata", brdata, 32'd0);

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].a, VECS[i].w, VECS[i].r, VECS[i].d, 8'h00);
         check("R2", "sel", {31'd0, sel}, {31'd0, VECS[i].e_sel});
         check("R4", "off", off, VECS[i].e_off);
         check("R5", "wr", {31'd0, owr}, {31'd0, VECS[i].w & VECS[i].e_sel});
         check("R6", "rd", {31'd0, ord}, {31'd0, VECS[i].r & VECS[i].e_sel});
         check("R7", "rdata", brdata, VECS[i].e_rd);
      end

      // R1: bit 30 is inside the window, so the compartment number changes
      apply(32'h4000_1400, 1'b1, 1'b0, 32'h1, 8'h00);
      check("R1", "bit30 sel", {31'd0, sel}, 32'd0);
      // R3: the low bits and bit 31 have no effect on sel
      apply(32'h8000_13FF, 1'b0, 1'b0, 32'h0, 8'h00);
      check("R3", "low/bit31 sel", {31'd0, sel}, 32'd1);
      check("R3", "low/bit31 off", off, 32'h0000_03FF);

      // R8: the single-compartment instance owns compartment 0 only
      apply(32'h0000_03FF, 1'b1, 1'b1, 32'h0, 8'hA5);
      check("R8", "single sel", {31'd0, sel1}, 32'd1);
      check("R8", "single off", off1, 32'h0000_03FF);
      check("R8", "single rdata", {24'd0, brdata1}, 32'h0000_00A5);
      check("R8", "single wr", {31'd0, owr1}, 32'd1);
      apply(32'h0000_0400, 1'b1, 1'b1, 32'h0, 8'hA5);
      check("R8", "single next sel", {31'd0, sel1}, 32'd0);
      check("R8", "single next rd", {31'd0, ord1}, 32'd0);
      check("R8", "single next rdata", {24'd0, brdata1}, 32'd0);
      apply(32'h8000_0000, 1'b0, 1'b1, 32'h0, 8'h3C);
      check("R8", "single bit31 sel", {31'd0, sel1}, 32'd1);
      check("R8", "single bit31 rd", {31'd0, ord1}, 32'd1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule